// File: doc/BRIEF.md
# JTAG Instruction Register and Data-Path Selector

This block is the instruction side of a JTAG test access port with a 3-bit instruction. A separate TAP sequencer supplies one-hot state strobes. This block holds the instruction shift stage and the parallel instruction. It decodes the instruction into a data-register selection. It also owns the serial data registers that the selection places between TDI and TDO: a single bypass cell, a 10-bit debug register and a 3-bit programming register.

The selection is kept in its own register, apart from the instruction. Several encodings therefore share one path: three codes mean bypass. Codes with no function (the two mandatory boundary-scan codes and the reserved code) can be loaded without disturbing the current path. The two private data registers each have a parallel output. The output is refreshed on the falling edge of TCK in update-DR. The register reloads from that output in capture-DR, so the value written can be read back through the scan chain. TDO is launched on the falling edge of TCK and is qualified by an output enable.

The selection register has three named states: `DR_BYP`, `DR_DBG` and `DR_PRG`. It moves as follows:
- Any state goes to `DR_BYP` on test-logic-reset or asynchronous reset.
- Any state goes to `DR_BYP` on update-IR with code 011b, 101b or 111b.
- Any state goes to `DR_DBG` on update-IR with 010b.
- Any state goes to `DR_PRG` on update-IR with 100b.
- The state is unchanged on update-IR with 000b, 001b or 110b, and in all other TAP states.

Top module: `jtag_ir_dpath`

## Requirements
- R1: While `trst_n` is low, `instr_q` is 011b, the selected path is the bypass cell, `dbg_par` and `prg_par` are zero, and `tdo` and `tdo_oe` are both 0.
- R2: In capture-IR, the instruction shift stage loads 001b on the rising edge of TCK. The following shift-IR cycles present bit 0 first on `tdo`, giving the sequence 1, 0, 0.
- R3: In shift-IR, each rising edge of TCK moves TDI into bit 2 of the shift stage and moves the contents one place toward bit 0. An instruction is therefore applied least significant bit first.
- R4: `instr_q` loads from the shift stage on the falling edge of TCK in update-IR. It holds in every other state except test-logic-reset. The shift stage holds while no capture-IR or shift-IR strobe is active, for example in pause-IR and the exit states.
- R5: A test-logic-reset strobe sets `instr_q` to 011b and selects the bypass cell on the falling edge of TCK.
- R6: Codes 011b, 101b and 111b select a 1-bit bypass path. That cell captures 0 in capture-DR.
- R7: Code 010b selects a 10-bit debug path. Code 100b selects a 3-bit programming path.
- R8: Codes 000b, 001b and 110b are still loaded into `instr_q`. They leave the selected data path and its length unchanged.
- R9: In capture-DR, the selected private register loads its own parallel output. In update-DR, on the falling edge of TCK, only the selected register copies its shift contents to its parallel output.
- R10: On each falling edge of TCK, `tdo` takes the shift stage's bit 0 in shift-IR and the selected data register's bit 0 in shift-DR, with `tdo_oe` = 1. In all other states, `tdo` = 0 and `tdo_oe` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tck | input | 1 | Test clock |
| trst_n | input | 1 | Asynchronous TAP reset, active low |
| tdi | input | 1 | Serial test data in |
| tap_tlr | input | 1 | Sequencer is in test-logic-reset |
| tap_cap_ir | input | 1 | Sequencer is in capture-IR |
| tap_shift_ir | input | 1 | Sequencer is in shift-IR |
| tap_upd_ir | input | 1 | Sequencer is in update-IR |
| tap_cap_dr | input | 1 | Sequencer is in capture-DR |
| tap_shift_dr | input | 1 | Sequencer is in shift-DR |
| tap_upd_dr | input | 1 | Sequencer is in update-DR |
| tdo | output | 1 | Serial test data out, launched on falling TCK |
| tdo_oe | output | 1 | Output enable for TDO |
| instr_q | output | 3 | Parallel instruction |
| dbg_par | output | 10 | Parallel contents of the debug data register |
| prg_par | output | 3 | Parallel contents of the programming data register |

## Verification
The bench builds the block with its default parameters: a 3-bit instruction, a 10-bit debug register and a 3-bit programming register. With a 3-bit instruction, all eight codes can be swept from each of the three possible prior selections. Path length is measured by flushing 16 zeros, then timing a single 1 from TDI to TDO. That window covers every path length, so length comes out as plain arithmetic. The short private registers also let exact bit patterns be written through update-DR and read back in full after capture-DR.

// File: rtl/jir_pkg.sv
package jir_pkg;

    // Data register placed between TDI and TDO
    typedef enum logic [1:0] {
        DR_BYP = 2'd0,
        DR_DBG = 2'd1,
        DR_PRG = 2'd2
    } dr_sel_e;

    // Decoded meaning of an instruction code
    typedef enum logic [1:0] {
        OP_NOP = 2'd0,
        OP_BYP = 2'd1,
        OP_DBG = 2'd2,
        OP_PRG = 2'd3
    } ir_op_e;

endpackage

// File: rtl/jir_ir_stage.sv
module jir_ir_stage
    import jir_pkg::*;
#(
    parameter int                      IR_W      = 3,
    parameter logic [IR_W-1:0]         CODE_CAPT = 3'b001,
    parameter logic [IR_W-1:0]         CODE_RST  = 3'b011,
    parameter logic [IR_W-1:0]         CODE_DBG  = 3'b010,
    parameter logic [IR_W-1:0]         CODE_PRG  = 3'b100,
    parameter logic [(1<<IR_W)-1:0]    BYP_SET   = 8'hA8
) (
    input  logic            tck,
    input  logic            trst_n,
    input  logic            tdi,
    input  logic            st_tlr,
    input  logic            st_cap,
    input  logic            st_shift,
    input  logic            st_upd,
    output logic [IR_W-1:0] sh_o,
    output logic [IR_W-1:0] ir_o,
    output dr_sel_e         sel_o
);

    logic [IR_W-1:0] sh_q;
    logic [IR_W-1:0] ir_q;
    dr_sel_e         sel_q;
    dr_sel_e         sel_d;
    ir_op_e          op;

    // Instruction shift stage, rising edge
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            sh_q <= CODE_CAPT;
        else if (st_cap)
            sh_q <= CODE_CAPT;
        else if (st_shift)
            sh_q <= {tdi, sh_q[IR_W-1:1]};
    end

    // Classify the code waiting in the shift stage
    always_comb begin
        if (BYP_SET[sh_q])
            op = OP_BYP;
        else if (sh_q == CODE_DBG)
            op = OP_DBG;
        else if (sh_q == CODE_PRG)
            op = OP_PRG;
        else
            op = OP_NOP;
    end

    // Next selection state
    always_comb begin
        sel_d = sel_q;
        if (st_tlr) begin
            sel_d = DR_BYP;
        end else if (st_upd) begin
            unique case (op)
                OP_BYP: sel_d = DR_BYP;
                OP_DBG: sel_d = DR_DBG;
                OP_PRG: sel_d = DR_PRG;
                OP_NOP: sel_d = sel_q;
            endcase
        end
    end

    // Selection state register, falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)
            sel_q <= DR_BYP;
        else
            sel_q <= sel_d;
    end

    // Parallel instruction, falling edge
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)
            ir_q <= CODE_RST;
        else if (st_tlr)
            ir_q <= CODE_RST;
        else if (st_upd)
            ir_q <= sh_q;
    end

    assign sh_o  = sh_q;
    assign ir_o  = ir_q;
    assign sel_o = sel_q;

endmodule

// File: rtl/jir_dr_reg.sv
module jir_dr_reg #(
    parameter int W = 10
) (
    input  logic         tck,
    input  logic         trst_n,
    input  logic         tdi,
    input  logic         act,
    input  logic         st_cap,
    input  logic         st_shift,
    input  logic         st_upd,
    output logic         lsb_o,
    output logic [W-1:0] par_o
);

    logic [W-1:0] sh_q;
    logic [W-1:0] par_q;

    // Serial stage: capture parallel value, then shift toward bit 0
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            sh_q <= '0;
        else if (act && st_cap)
            sh_q <= par_q;
        else if (act && st_shift)
            sh_q <= {tdi, sh_q[W-1:1]};
    end

    // Parallel output, falling edge of update
    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n)
            par_q <= '0;
        else if (act && st_upd)
            par_q <= sh_q;
    end

    assign lsb_o = sh_q[0];
    assign par_o = par_q;

endmodule

// File: rtl/jir_tdo_drv.sv
module jir_tdo_drv (
    input  logic tck,
    input  logic trst_n,
    input  logic in_ir,
    input  logic in_dr,
    input  logic ir_bit,
    input  logic dr_bit,
    output logic tdo,
    output logic tdo_oe
);

    always_ff @(negedge tck or negedge trst_n) begin
        if (!trst_n) begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end else if (in_ir) begin
            tdo    <= ir_bit;
            tdo_oe <= 1'b1;
        end else if (in_dr) begin
            tdo    <= dr_bit;
            tdo_oe <= 1'b1;
        end else begin
            tdo    <= 1'b0;
            tdo_oe <= 1'b0;
        end
    end

endmodule

// File: rtl/jtag_ir_dpath.sv
module jtag_ir_dpath
    import jir_pkg::*;
#(
    parameter int                   IR_W      = 3,
    parameter int                   DBG_W     = 10,
    parameter int                   PRG_W     = 3,
    parameter logic [IR_W-1:0]      CODE_CAPT = 3'b001,
    parameter logic [IR_W-1:0]      CODE_RST  = 3'b011,
    parameter logic [IR_W-1:0]      CODE_DBG  = 3'b010,
    parameter logic [IR_W-1:0]      CODE_PRG  = 3'b100,
    parameter logic [(1<<IR_W)-1:0] BYP_SET   = 8'hA8
) (
    input  logic             tck,
    input  logic             trst_n,
    input  logic             tdi,
    input  logic             tap_tlr,
    input  logic             tap_cap_ir,
    input  logic             tap_shift_ir,
    input  logic             tap_upd_ir,
    input  logic             tap_cap_dr,
    input  logic             tap_shift_dr,
    input  logic             tap_upd_dr,
    output logic             tdo,
    output logic             tdo_oe,
    output logic [IR_W-1:0]  instr_q,
    output logic [DBG_W-1:0] dbg_par,
    output logic [PRG_W-1:0] prg_par
);

    logic [IR_W-1:0] ir_sh;
    dr_sel_e         sel_q;
    logic            byp_q;
    logic            dbg_lsb;
    logic            prg_lsb;
    logic            dr_bit;

    jir_ir_stage #(
        .IR_W      (IR_W),
        .CODE_CAPT (CODE_CAPT),
        .CODE_RST  (CODE_RST),
        .CODE_DBG  (CODE_DBG),
        .CODE_PRG  (CODE_PRG),
        .BYP_SET   (BYP_SET)
    ) u_ir (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .st_tlr   (tap_tlr),
        .st_cap   (tap_cap_ir),
        .st_shift (tap_shift_ir),
        .st_upd   (tap_upd_ir),
        .sh_o     (ir_sh),
        .ir_o     (instr_q),
        .sel_o    (sel_q)
    );

    // Single bypass cell, captures zero
    always_ff @(posedge tck or negedge trst_n) begin
        if (!trst_n)
            byp_q <= 1'b0;
        else if (sel_q == DR_BYP && tap_cap_dr)
            byp_q <= 1'b0;
        else if (sel_q == DR_BYP && tap_shift_dr)
            byp_q <= tdi;
    end

    jir_dr_reg #(.W(DBG_W)) u_dbg (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .act      (sel_q == DR_DBG),
        .st_cap   (tap_cap_dr),
        .st_shift (tap_shift_dr),
        .st_upd   (tap_upd_dr),
        .lsb_o    (dbg_lsb),
        .par_o    (dbg_par)
    );

    jir_dr_reg #(.W(PRG_W)) u_prg (
        .tck      (tck),
        .trst_n   (trst_n),
        .tdi      (tdi),
        .act      (sel_q == DR_PRG),
        .st_cap   (tap_cap_dr),
        .st_shift (tap_shift_dr),
        .st_upd   (tap_upd_dr),
        .lsb_o    (prg_lsb),
        .par_o    (prg_par)
    );

    // Serial return path for the selected data register
    always_comb begin
        unique case (sel_q)
            DR_DBG:  dr_bit = dbg_lsb;
            DR_PRG:  dr_bit = prg_lsb;
            default: dr_bit = byp_q;
        endcase
    end

    jir_tdo_drv u_tdo (
        .tck    (tck),
        .trst_n (trst_n),
        .in_ir  (tap_shift_ir),
        .in_dr  (tap_shift_dr),
        .ir_bit (ir_sh[0]),
        .dr_bit (dr_bit),
        .tdo    (tdo),
        .tdo_oe (tdo_oe)
    );

endmodule

// File: rtl/jir_checker.sv
module jir_checker
    import jir_pkg::*;
#(
    parameter int                   IR_W      = 3,
    parameter logic [IR_W-1:0]      CODE_CAPT = 3'b001,
    parameter logic [IR_W-1:0]      CODE_RST  = 3'b011,
    parameter logic [IR_W-1:0]      CODE_DBG  = 3'b010,
    parameter logic [IR_W-1:0]      CODE_PRG  = 3'b100,
    parameter logic [(1<<IR_W)-1:0] BYP_SET   = 8'hA8
) (
    input logic            tck,
    input logic            trst_n,
    input logic            tap_tlr,
    input logic            tap_cap_ir,
    input logic            tap_shift_ir,
    input logic            tap_upd_ir,
    input logic            tap_shift_dr,
    input logic            tdo,
    input logic            tdo_oe,
    input logic [IR_W-1:0] instr_q,
    input logic [IR_W-1:0] ir_sh,
    input dr_sel_e         sel_q
);

    a_r2_capture_pattern: assert property (@(posedge tck) disable iff (!trst_n)
        tap_cap_ir |=> (ir_sh == CODE_CAPT));

    a_r4_instr_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (!tap_upd_ir && !tap_tlr) |-> $stable(instr_q));

    a_r4_shift_hold: assert property (@(posedge tck) disable iff (!trst_n)
        (!tap_cap_ir && !tap_shift_ir) |=> $stable(ir_sh));

    a_r5_reset_state: assert property (@(posedge tck) disable iff (!trst_n)
        tap_tlr |-> (instr_q == CODE_RST && sel_q == DR_BYP));

    a_r7_debug_select: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_upd_ir && !tap_tlr && ir_sh == CODE_DBG) |-> (sel_q == DR_DBG));

    a_r7_prog_select: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_upd_ir && !tap_tlr && ir_sh == CODE_PRG) |-> (sel_q == DR_PRG));

    a_r8_nop_keeps_path: assert property (@(posedge tck) disable iff (!trst_n)
        (tap_upd_ir && !tap_tlr && !BYP_SET[ir_sh] && ir_sh != CODE_DBG && ir_sh != CODE_PRG)
        |-> $stable(sel_q));

    a_r10_oe_only_shift: assert property (@(posedge tck) disable iff (!trst_n)
        tdo_oe |-> (tap_shift_ir || tap_shift_dr));

    a_r10_idle_low: assert property (@(posedge tck) disable iff (!trst_n)
        !tdo_oe |-> !tdo);

endmodule

bind jtag_ir_dpath jir_checker #(
    .IR_W      (IR_W),
    .CODE_CAPT (CODE_CAPT),
    .CODE_RST  (CODE_RST),
    .CODE_DBG  (CODE_DBG),
    .CODE_PRG  (CODE_PRG),
    .BYP_SET   (BYP_SET)
) u_chk (
    .tck          (tck),
    .trst_n       (trst_n),
    .tap_tlr      (tap_tlr),
    .tap_cap_ir   (tap_cap_ir),
    .tap_shift_ir (tap_shift_ir),
    .tap_upd_ir   (tap_upd_ir),
    .tap_shift_dr (tap_shift_dr),
    .tdo          (tdo),
    .tdo_oe       (tdo_oe),
    .instr_q      (instr_q),
    .ir_sh        (ir_sh),
    .sel_q        (sel_q)
);

// File: tb/jtag_ir_dpath_bench.sv
`timescale 1ns/1ps
module jtag_ir_dpath_bench;

    localparam int S_TLR = 0;
    localparam int S_CIR = 1;
    localparam int S_SIR = 2;
    localparam int S_UIR = 3;
    localparam int S_CDR = 4;
    localparam int S_SDR = 5;
    localparam int S_UDR = 6;

    logic       tck = 1'b0;
    logic       trst_n = 1'b0;
    logic       tdi = 1'b0;
    logic [6:0] st = '0;
    logic       tdo, tdo_oe;
    logic [2:0] instr_q;
    logic [9:0] dbg_par;
    logic [2:0] prg_par;

    int  n_cmp = 0;
    int  n_bad = 0;
    bit  done  = 0;
    logic last_oe;

    always #2 tck = ~tck;

    jtag_ir_dpath u_jtag_ir_dpath (
        .tck          (tck),
        .trst_n       (trst_n),
        .tdi          (tdi),
        .tap_tlr      (st[S_TLR]),
        .tap_cap_ir   (st[S_CIR]),
        .tap_shift_ir (st[S_SIR]),
        .tap_upd_ir   (st[S_UIR]),
        .tap_cap_dr   (st[S_CDR]),
        .tap_shift_dr (st[S_SDR]),
        .tap_upd_dr   (st[S_UDR]),
        .tdo          (tdo),
        .tdo_oe       (tdo_oe),
        .instr_q      (instr_q),
        .dbg_par      (dbg_par),
        .prg_par      (prg_par)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One TCK cycle in a given state; tdo is sampled after the falling edge
    task automatic cyc(input int s, input logic d, output logic o);
        st  = '0;
        if (s >= 0) st[s] = 1'b1;
        tdi = d;
        @(negedge tck); #1;
        o       = tdo;
        last_oe = tdo_oe;
        @(posedge tck); #1;
    endtask

    task automatic idle();
        logic o;
        cyc(-1, 1'b0, o);
    endtask

    task automatic load_ir(input logic [2:0] code, output logic [2:0] seen);
        logic o;
        cyc(S_CIR, 1'b0, o);
        for (int i = 0; i < 3; i++) begin
            cyc(S_SIR, code[i], o);
            seen[i] = o;
            chk(last_oe == 1'b1, "R10", int'(last_oe), 1);
        end
        cyc(-1, 1'b0, o);
        cyc(S_UIR, 1'b0, o);
        cyc(-1, 1'b0, o);
    endtask

    task automatic measure(output int len);
        logic o;
        len = 0;
        cyc(S_CDR, 1'b0, o);
        for (int i = 0; i < 16; i++) cyc(S_SDR, 1'b0, o);
        cyc(S_SDR, 1'b1, o);
        for (int r = 1; r <= 20; r++) begin
            cyc(S_SDR, 1'b0, o);
            if (o && len == 0) len = r;
        end
        cyc(-1, 1'b0, o);
    endtask

    function automatic int exp_len(input logic [2:0] c, input int prev);
        case (c)
            3'b011, 3'b101, 3'b111: return 1;
            3'b010:                 return 10;
            3'b100:                 return 3;
            default:                return prev;
        endcase
    endfunction

    initial begin
        #(4 * 150000);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [2:0] seen;
        logic       o;
        int         len;
        logic [2:0] prevs [3];
        prevs[0] = 3'b011; prevs[1] = 3'b010; prevs[2] = 3'b100;

        repeat (3) @(posedge tck);
        #1;
        // R1: state while reset is held
        chk(instr_q == 3'b011, "R1", instr_q, 3);
        chk(dbg_par == 0 && prg_par == 0, "R1", int'(dbg_par) + int'(prg_par), 0);
        chk(tdo == 0 && tdo_oe == 0, "R1", int'({tdo, tdo_oe}), 0);
        trst_n = 1'b1;
        @(posedge tck); #1;
        measure(len);
        chk(len == 1, "R1", len, 1);

        // Sweep every code from every prior selection (R2 R3 R4 R6 R7 R8)
        foreach (prevs[p]) begin
            for (int c = 0; c < 8; c++) begin
                int    want;
                string tag;
                load_ir(prevs[p], seen);
                chk(seen == 3'b001, "R2", seen, 1);
                load_ir(3'(c), seen);
                chk(seen == 3'b001, "R2", seen, 1);
                chk(instr_q == 3'(c), "R3", instr_q, c);
                want = exp_len(3'(c), exp_len(prevs[p], 0));
                if (c == 3 || c == 5 || c == 7) tag = "R6";
                else if (c == 2 || c == 4)      tag = "R7";
                else                            tag = "R8";
                measure(len);
                chk(len == want, tag, len, want);
            end
        end

        // R5: test-logic-reset from debug selection
        load_ir(3'b010, seen);
        cyc(S_TLR, 1'b0, o);
        chk(instr_q == 3'b011, "R5", instr_q, 3);
        measure(len);
        chk(len == 1, "R5", len, 1);

        // R4: shift stage and instruction hold across a pause
        cyc(S_CIR, 1'b0, o);
        cyc(S_SIR, 1'b0, o);
        chk(o == 1'b1, "R2", o, 1);
        cyc(-1, 1'b0, o);
        chk(o == 0 && last_oe == 0, "R10", int'({o, last_oe}), 0);
        cyc(-1, 1'b0, o);
        chk(instr_q == 3'b011, "R4", instr_q, 3);
        cyc(S_SIR, 1'b0, o);
        chk(o == 1'b0, "R4", o, 0);
        cyc(S_SIR, 1'b1, o);
        chk(o == 1'b0, "R4", o, 0);
        cyc(-1, 1'b0, o);
        chk(instr_q == 3'b011, "R4", instr_q, 3);
        cyc(S_UIR, 1'b0, o);
        idle();
        chk(instr_q == 3'b100, "R4", instr_q, 4);
        measure(len);
        chk(len == 3, "R7", len, 3);

        // R9: write programming register, read it back
        cyc(S_CDR, 1'b0, o);
        cyc(S_SDR, 1'b1, o);
        cyc(S_SDR, 1'b0, o);
        cyc(S_SDR, 1'b1, o);
        cyc(-1, 1'b0, o);
        cyc(S_UDR, 1'b0, o);
        idle();
        chk(prg_par == 3'b101, "R9", prg_par, 5);
        chk(dbg_par == 10'd0, "R9", dbg_par, 0);
        begin
            logic [2:0] rb;
            cyc(S_CDR, 1'b0, o);
            for (int i = 0; i < 3; i++) begin
                cyc(S_SDR, 1'b0, o);
                rb[i] = o;
            end
            idle();
            chk(rb == 3'b101, "R9", rb, 5);
        end

        // R9: write debug register, read it back
        load_ir(3'b010, seen);
        begin
            logic [9:0] pat = 10'h2C9;
            logic [9:0] rb;
            cyc(S_CDR, 1'b0, o);
            for (int i = 0; i < 10; i++) cyc(S_SDR, pat[i], o);
            cyc(-1, 1'b0, o);
            cyc(S_UDR, 1'b0, o);
            idle();
            chk(dbg_par == pat, "R9", dbg_par, pat);
            chk(prg_par == 3'b101, "R9", prg_par, 5);
            cyc(S_CDR, 1'b0, o);
            for (int i = 0; i < 10; i++) begin
                cyc(S_SDR, 1'b0, o);
                rb[i] = o;
                chk(last_oe == 1'b1, "R10", int'(last_oe), 1);
            end
            idle();
            chk(rb == pat, "R9", rb, pat);
            chk(tdo == 0 && tdo_oe == 0, "R10", int'({tdo, tdo_oe}), 0);
        end

        // R8: no-op code keeps the debug path even after capture/shift
        load_ir(3'b000, seen);
        measure(len);
        chk(len == 10, "R8", len, 10);

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule